// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one access request into the stream of column addresses that a synchronous DRAM burst walks through. A command sequencer raises `start` together with the first column, the burst length code, the ordering type and the access direction. From the next cycle on, the block presents one column per clock, flags the final column of a fixed-length burst, and drops `beat_valid` once the burst is over. A fixed-length burst stays inside an aligned block of columns whose size is the burst length. A whole-page burst runs on through the row, wrapping at its end, until it is stopped.

A write can be forced to a single column by a mode input while reads keep the programmed length. A `stop` input cuts a running burst short. A new `start` always takes over at once, even in the middle of a burst. All outputs come from registers.

Top module: `sdr_burst_col_gen`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `beat_valid` and `beat_last` are 0 and `beat_col` is 0.
- R2: A `start` sampled at a rising edge makes `beat_valid` 1 in the following cycle, with `beat_col` equal to the sampled `start_col`. After that, one further column is presented in each later cycle.
- R3: `bl_code` selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives a whole page. The unused codes 4, 5 and 6 give a single beat.
- R4: With `interleave` = 0 and a fixed length BL = 2^k, beat i carries column bits below k equal to (start offset + i) mod BL. The bits at k and above are copied from `start_col`.
- R5: With `interleave` = 1 and a fixed length BL = 2^k, beat i carries column bits below k equal to (start offset XOR i). The bits at k and above are copied from `start_col`.
- R6: `beat_last` is 1 exactly on beat BL-1 of a fixed-length burst. In the cycle after that beat, `beat_valid` is 0 unless a new `start` was sampled.
- R7: A whole-page burst (code 7) presents (start_col + i) mod 2^COL_W, so it goes from column 511 to column 0. It never raises `beat_last`, it runs until stopped or restarted, and it ignores `interleave`.
- R8: When `is_write` and `write_single` are both 1 at `start`, the burst is a single beat at `start_col` with `beat_last` = 1, whatever the code. With `is_write` = 0, `write_single` has no effect.
- R9: `stop` sampled without `start` ends a running burst: `beat_valid` is 0 from the next cycle. `stop` while idle has no effect.
- R10: `start` takes priority over a running burst and over `stop` in the same cycle. The new burst begins as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new burst with the fields below |
| is_write | input | 1 | 1 when the burst is a write |
| start_col | input | COL_W | First column of the burst |
| bl_code | input | 3 | Burst length code (see R3) |
| interleave | input | 1 | 0 sequential order, 1 interleaved order |
| write_single | input | 1 | Force writes to a single column |
| stop | input | 1 | Terminate the running burst |
| beat_valid | output | 1 | A column is presented this cycle |
| beat_col | output | COL_W | Column for the current beat |
| beat_last | output | 1 | Final beat of a fixed-length burst |

## Verification
The bench builds the block with its default COL_W of 9, which gives a 512-column page. With this width, a whole-page burst started near column 511 crosses the wrap to 0 within a few cycles. Starting columns with high bits set show that bits above the block boundary stay fixed for lengths 2, 4 and 8, and odd start offsets show where the sequential and interleaved orders differ. Restarts on the last beat, stop pulses while idle and a start together with stop exercise the priority rules.

// File: rtl/sdr_burst_pkg.sv
package sdr_burst_pkg;

  localparam logic [2:0] BLC_1    = 3'd0;
  localparam logic [2:0] BLC_2    = 3'd1;
  localparam logic [2:0] BLC_4    = 3'd2;
  localparam logic [2:0] BLC_8    = 3'd3;
  localparam logic [2:0] BLC_PAGE = 3'd7;

  // log2 of the block size for fixed-length codes; unused codes map to 1 beat
  function automatic logic [1:0] blk_shift(input logic [2:0] code);
    case (code)
      BLC_2:   return 2'd1;
      BLC_4:   return 2'd2;
      BLC_8:   return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/sdr_burst_len_dec.sv
module sdr_burst_len_dec #(
  parameter int COL_W = 9
) (
  input  logic [2:0]       bl_code,
  input  logic             is_write,
  input  logic             write_single,
  input  logic             interleave,
  output logic [COL_W-1:0] mask,
  output logic             full_page,
  output logic             ilv_eff
);
  import sdr_burst_pkg::*;

  logic       single;
  logic [1:0] shift;

  always_comb begin
    single    = is_write && write_single;
    shift     = single ? 2'd0 : blk_shift(bl_code);
    full_page = !single && (bl_code == BLC_PAGE);
    ilv_eff   = interleave && !full_page;
  end

  // block mask: low ones up to the block size, all ones for a page
  for (genvar b = 0; b < COL_W; b++) begin : g_mask
    assign mask[b] = full_page || (b < int'(shift));
  end

endmodule

// File: rtl/sdr_burst_seq_ctl.sv
module sdr_burst_seq_ctl #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             stop,
  input  logic [COL_W-1:0] in_base,
  input  logic [COL_W-1:0] in_mask,
  input  logic             in_full,
  input  logic             in_ilv,
  output logic [COL_W-1:0] sel_base,
  output logic [COL_W-1:0] sel_mask,
  output logic [COL_W-1:0] sel_idx,
  output logic             sel_ilv,
  output logic             emit,
  output logic             emit_last,
  output logic             full_r,
  output logic [COL_W-1:0] mask_r
);

  logic             act_r;
  logic             ilv_r;
  logic [COL_W-1:0] base_r;
  logic [COL_W-1:0] idx_r;
  logic [COL_W-1:0] nxt_idx;
  logic             cur_last;

  always_comb begin
    nxt_idx  = idx_r + 1'b1;
    cur_last = act_r && !full_r && (idx_r == mask_r);
    sel_base = base_r;
    sel_mask = mask_r;
    sel_ilv  = ilv_r;
    sel_idx  = nxt_idx;
    emit      = 1'b0;
    emit_last = 1'b0;
    if (start) begin
      sel_base  = in_base;
      sel_mask  = in_mask;
      sel_ilv   = in_ilv;
      sel_idx   = '0;
      emit      = 1'b1;
      emit_last = !in_full && (in_mask == '0);
    end else if (act_r && !stop && !cur_last) begin
      emit      = 1'b1;
      emit_last = !full_r && (nxt_idx == mask_r);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_r  <= 1'b0;
      ilv_r  <= 1'b0;
      full_r <= 1'b0;
      base_r <= '0;
      mask_r <= '0;
      idx_r  <= '0;
    end else begin
      act_r <= emit;
      if (start) begin
        base_r <= in_base;
        mask_r <= in_mask;
        full_r <= in_full;
        ilv_r  <= in_ilv;
        idx_r  <= '0;
      end else if (emit) begin
        idx_r <= nxt_idx;
      end
    end
  end

  // beat index of a fixed burst never leaves the block
  p_idx_in_block_r6: assert property (@(posedge clk) disable iff (rst)
    (act_r && !full_r) |-> ((idx_r & ~mask_r) == '0));

  // an index at the block end is never followed by another beat of the same burst
  p_end_halts_r6: assert property (@(posedge clk) disable iff (rst)
    (cur_last && !start) |=> !act_r);

endmodule

// File: rtl/sdr_burst_addr_gen.sv
module sdr_burst_addr_gen #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] mask,
  input  logic [COL_W-1:0] idx,
  input  logic             ilv,
  output logic [COL_W-1:0] addr
);

  logic [COL_W-1:0] sum;
  assign sum = base + idx;

  // inside the block: wrapped sum or xor; outside: start bits kept
  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign addr[b] = !mask[b] ? base[b] : (ilv ? (base[b] ^ idx[b]) : sum[b]);
  end

endmodule

// File: rtl/sdr_burst_col_gen.sv
module sdr_burst_col_gen #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             is_write,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       bl_code,
  input  logic             interleave,
  input  logic             write_single,
  input  logic             stop,
  output logic             beat_valid,
  output logic [COL_W-1:0] beat_col,
  output logic             beat_last
);

  logic [COL_W-1:0] dec_mask;
  logic             dec_full;
  logic             dec_ilv;
  logic [COL_W-1:0] sel_base;
  logic [COL_W-1:0] sel_mask;
  logic [COL_W-1:0] sel_idx;
  logic             sel_ilv;
  logic             emit;
  logic             emit_last;
  logic             full_r;
  logic [COL_W-1:0] mask_r;
  logic [COL_W-1:0] nxt_col;

  sdr_burst_len_dec #(.COL_W(COL_W)) len_i (
    .bl_code      (bl_code),
    .is_write     (is_write),
    .write_single (write_single),
    .interleave   (interleave),
    .mask         (dec_mask),
    .full_page    (dec_full),
    .ilv_eff      (dec_ilv)
  );

  sdr_burst_seq_ctl #(.COL_W(COL_W)) ctl_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .stop      (stop),
    .in_base   (start_col),
    .in_mask   (dec_mask),
    .in_full   (dec_full),
    .in_ilv    (dec_ilv),
    .sel_base  (sel_base),
    .sel_mask  (sel_mask),
    .sel_idx   (sel_idx),
    .sel_ilv   (sel_ilv),
    .emit      (emit),
    .emit_last (emit_last),
    .full_r    (full_r),
    .mask_r    (mask_r)
  );

  sdr_burst_addr_gen #(.COL_W(COL_W)) addr_i (
    .base (sel_base),
    .mask (sel_mask),
    .idx  (sel_idx),
    .ilv  (sel_ilv),
    .addr (nxt_col)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_valid <= 1'b0;
      beat_last  <= 1'b0;
      beat_col   <= '0;
    end else begin
      beat_valid <= emit;
      beat_last  <= emit_last;
      if (emit) beat_col <= nxt_col;
    end
  end

  p_first_beat_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> (beat_valid && beat_col == $past(start_col)));

  p_stay_in_block_r4: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && $past(beat_valid) && !$past(start)) |->
      (((beat_col ^ $past(beat_col)) & ~mask_r) == '0));

  p_last_then_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && beat_last && !start) |=> !beat_valid);

  p_page_no_last_r7: assert property (@(posedge clk) disable iff (rst)
    full_r |-> !beat_last);

  p_single_write_r8: assert property (@(posedge clk) disable iff (rst)
    (start && is_write && write_single) |=> (beat_valid && beat_last));

  p_stop_ends_r9: assert property (@(posedge clk) disable iff (rst)
    (stop && !start) |=> !beat_valid);

endmodule

// File: tb/sdr_burst_col_gen_tb.sv
module sdr_burst_col_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int COL_W      = 9;
  localparam int PAGE       = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic             is_write = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0]       bl_code = '0;
  logic             interleave = 1'b0;
  logic             write_single = 1'b0;
  logic             stop = 1'b0;
  logic             beat_valid;
  logic [COL_W-1:0] beat_col;
  logic             beat_last;

  int    vectors = 0;
  int    fails   = 0;
  string req     = "R1";

  sdr_burst_col_gen #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .is_write(is_write),
    .start_col(start_col), .bl_code(bl_code), .interleave(interleave),
    .write_single(write_single), .stop(stop),
    .beat_valid(beat_valid), .beat_col(beat_col), .beat_last(beat_last)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  int m_act = 0, m_i = 0, m_bs = 1, m_full = 0, m_ilv = 0, m_s = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_act = 0;
    end else if (start) begin
      m_s = int'(start_col); m_i = 0; m_act = 1; m_full = 0; m_ilv = int'(interleave);
      if (is_write && write_single) m_bs = 1;
      else case (bl_code)
        3'd1: m_bs = 2;
        3'd2: m_bs = 4;
        3'd3: m_bs = 8;
        3'd7: begin m_bs = PAGE; m_full = 1; m_ilv = 0; end
        default: m_bs = 1;
      endcase
    end else if (m_act != 0) begin
      if (stop) m_act = 0;
      else if (m_full == 0 && m_i == m_bs - 1) m_act = 0;
      else m_i = (m_i + 1) % PAGE;
    end
  end

  function automatic int exp_col();
    int off, low;
    if (m_full != 0) return (m_s + m_i) % PAGE;
    off = m_s % m_bs;
    low = (m_ilv != 0) ? (off ^ m_i) : ((off + m_i) % m_bs);
    return m_s - off + low;
  endfunction

  task automatic compare();
    int ev, el, ec;
    ev = (m_act != 0) ? 1 : 0;
    el = (m_act != 0 && m_full == 0 && m_i == m_bs - 1) ? 1 : 0;
    ec = exp_col();
    vectors++;
    if (int'(beat_valid) != ev || int'(beat_last) != el ||
        (ev == 1 && int'(beat_col) != ec) || (rst && beat_col != '0)) begin
      fails++;
      $display("FAIL %s t=%0t valid/last/col act=%0d/%0d/%0d exp=%0d/%0d/%0d",
               req, $time, beat_valid, beat_last, beat_col, ev, el, (ev == 1) ? ec : 0);
    end
  endtask

  task automatic tick(input logic st, input logic wr, input logic [COL_W-1:0] col,
                      input logic [2:0] code, input logic il, input logic ws, input logic sp);
    @(negedge clk);
    compare();
    start = st; is_write = wr; start_col = col; bl_code = code;
    interleave = il; write_single = ws; stop = sp;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) tick(1'b0, 1'b0, '0, 3'd0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    req = "R1"; idle(4);
    rst = 1'b0; idle(2);
    // R2 R4 R6: sequential, length 8, offset 6, high bits set
    req = "R2 R4 R6 seq8"; tick(1, 0, 9'h1F6, 3'd3, 0, 0, 0); idle(10);
    req = "R4 seq4"; tick(1, 0, 9'h0A3, 3'd2, 0, 0, 0); idle(6);
    req = "R4 seq2"; tick(1, 1, 9'h101, 3'd1, 0, 0, 0); idle(4);
    // R5 interleaved
    req = "R5 ilv8"; tick(1, 0, 9'h045, 3'd3, 1, 0, 0); idle(10);
    req = "R5 ilv4"; tick(1, 0, 9'h0A6, 3'd2, 1, 0, 0); idle(6);
    // R3 codes
    req = "R3 len1"; tick(1, 0, 9'h077, 3'd0, 0, 0, 0); idle(3);
    req = "R3 reserved"; tick(1, 0, 9'h0C4, 3'd5, 1, 0, 0); idle(3);
    // R7 whole page across the wrap, then stop (R9)
    req = "R7 page wrap"; tick(1, 0, 9'd509, 3'd7, 0, 0, 0); idle(6);
    req = "R9 page stop"; tick(0, 0, '0, 3'd0, 0, 0, 1); idle(3);
    req = "R7 page ilv ignored"; tick(1, 0, 9'd301, 3'd7, 1, 0, 0); idle(4);
    tick(0, 0, '0, 3'd0, 0, 0, 1); idle(2);
    // R8 single-location writes
    req = "R8 write single"; tick(1, 1, 9'h033, 3'd3, 0, 1, 0); idle(3);
    req = "R8 read keeps length"; tick(1, 0, 9'h033, 3'd3, 0, 1, 0); idle(10);
    req = "R8 write burst"; tick(1, 1, 9'h035, 3'd2, 1, 0, 0); idle(6);
    // R9 stop mid-burst and while idle
    req = "R9 stop mid"; tick(1, 0, 9'h010, 3'd3, 0, 0, 0); idle(2);
    tick(0, 0, '0, 3'd0, 0, 0, 1); idle(3);
    req = "R9 stop idle"; tick(0, 0, '0, 3'd0, 0, 0, 1); idle(3);
    // R10 restart mid-burst, start with stop, restart on last beat
    req = "R10 restart"; tick(1, 0, 9'h020, 3'd3, 0, 0, 0); idle(3);
    tick(1, 0, 9'h043, 3'd2, 0, 0, 0); idle(6);
    req = "R10 start beats stop"; tick(1, 0, 9'h15E, 3'd2, 1, 0, 1); idle(5);
    req = "R10 back to back"; tick(1, 0, 9'h0F1, 3'd1, 0, 0, 0); idle(1);
    tick(1, 0, 9'h1FF, 3'd7, 0, 0, 0); idle(3);
    tick(0, 0, '0, 3'd0, 0, 0, 1); idle(3);
    req = "R1 reset mid"; tick(1, 0, 9'h088, 3'd3, 0, 0, 0); idle(2);
    rst = 1'b1; idle(3); rst = 1'b0; idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired in %s", req);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule